// File: doc/BRIEF.md
# Rectangle Image Load Engine

The engine copies a rectangle of pixels from a stream of 32-bit source words into a byte-addressed frame memory. Software programs a pixel format, the frame pitch in pixels, a packed pair of horizontal bounds, a first destination line and a line count. Writing the line count through its start alias launches the load. The source stream delivers each rectangle line as whole words. A line's bytes are padded at its tail up to the next 4-byte boundary, and the engine throws those pad bytes away.

Pixels can be 2, 3 or 4 bytes wide. 3-byte pixels can span two source words, so a small byte buffer carries leftover bytes from one word into the next. This buffer is flushed at every line boundary. Each pixel leaves the engine as one frame-memory write: a byte address, the pixel value in the low bytes, and a byte count. When the final pixel of the final line has been written, the engine raises a single-cycle completion pulse and goes back to idle.

Top module: `rect_iload`

## Requirements
- R1: Register 0 bits [1:0] select the pixel size: code 0 means 2 bytes, code 1 means 3 bytes, codes 2 and 3 mean 4 bytes. Each pixel produces exactly one write with `wr_bytes` equal to that size and the pixel value aligned to bit 0 of `wr_data`.
- R2: The pixel at column x and line y is written at byte address (y·pitch + x)·size. The pitch comes from register 1 bits [15:0], in pixels.
- R3: Register 2 holds the inclusive right bound in bits [31:16] and the left bound in bits [15:0]. Every line writes exactly right − left + 1 pixels, from the left bound rightwards.
- R4: Each source line takes ceil(pixels·size / 4) words, and a new line always starts in a new word. Pad bytes at the end of a line never reach the frame memory.
- R5: Pixels are assembled little-endian from the source byte stream. For 3-byte pixels this includes pixels whose bytes span two source words.
- R6: `in_ready` is high only while a load runs and the current line still needs source words. No frame write happens while idle.
- R7: Register 3 bits [15:0] give the first destination line. A write to register 5 stores the line count and starts a load. A write to register 4 stores the same count but starts nothing.
- R8: After the last pixel write of a load, `done` is high for exactly one cycle, and the engine is idle at that point.
- R9: A start with a line count of zero, or with right bound less than left bound, gives a `done` pulse with no frame write and no source word taken.
- R10: Register writes made during a load, including a second start, do not change the running load and produce no extra `done`.
- R11: After reset, `in_ready`, `wr_en` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Source word valid |
| in_data | input | 32 | Source word, byte 0 in bits [7:0] |
| in_ready | output | 1 | Engine accepts the source word |
| wr_en | output | 1 | Frame write strobe |
| wr_addr | output | ADDR_W | Frame byte address of the pixel |
| wr_data | output | 32 | Pixel value, low bytes used |
| wr_bytes | output | 3 | Number of bytes to write (2, 3 or 4) |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a 3-byte pixel whose bytes span two source words while the line is also ending, because the buffer then holds live bytes and pad bytes together. The sweep walks every pixel size across line widths 1 to 6 and two left offsets, with one and three lines. This makes every pad length and every split position of a 3-byte pixel occur. The source valid signal drops on a fixed cadence so that gaps land at different points in the unpacking. One load is also disturbed by register writes and a second start issued while it runs.

// File: rtl/ilo_pkg.sv
package ilo_pkg;

    localparam int FIELD_W   = 16;
    localparam int WORD_W    = 32;
    localparam int BUF_BYTES = 8;

    localparam logic [2:0] RA_FMT    = 3'd0;
    localparam logic [2:0] RA_PITCH  = 3'd1;
    localparam logic [2:0] RA_XBND   = 3'd2;
    localparam logic [2:0] RA_YDST   = 3'd3;
    localparam logic [2:0] RA_LEN    = 3'd4;
    localparam logic [2:0] RA_LEN_GO = 3'd5;

    typedef struct packed {
        logic [1:0]         fmt;
        logic [FIELD_W-1:0] pitch;
        logic [FIELD_W-1:0] xl;
        logic [FIELD_W-1:0] xr;
        logic [FIELD_W-1:0] ydst;
        logic [FIELD_W-1:0] len;
    } cfg_t;

    function automatic logic [2:0] fmt_bytes(input logic [1:0] f);
        case (f)
            2'd0:    return 3'd2;
            2'd1:    return 3'd3;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/ilo_regs.sv
module ilo_regs
    import ilo_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output cfg_t        cfg,
    output logic        go
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
            go  <= 1'b0;
        end else begin
            go <= 1'b0;
            if (reg_we) begin
                case (reg_addr)
                    RA_FMT:   cfg.fmt   <= reg_wdata[1:0];
                    RA_PITCH: cfg.pitch <= reg_wdata[15:0];
                    RA_XBND: begin
                        cfg.xl <= reg_wdata[15:0];
                        cfg.xr <= reg_wdata[31:16];
                    end
                    RA_YDST:  cfg.ydst  <= reg_wdata[15:0];
                    RA_LEN:   cfg.len   <= reg_wdata[15:0];
                    RA_LEN_GO: begin
                        cfg.len <= reg_wdata[15:0];
                        go      <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/ilo_unpack.sv
module ilo_unpack
    import ilo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              push,
    input  logic [WORD_W-1:0] push_data,
    input  logic              pop,
    input  logic [2:0]        pop_bytes,
    output logic [3:0]        count,
    output logic [WORD_W-1:0] pixel
);
    localparam int BUF_W = BUF_BYTES * 8;

    logic [BUF_W-1:0] bytes_q;
    logic [3:0]       cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            bytes_q <= '0;
            cnt_q   <= '0;
        end else if (push) begin
            bytes_q <= bytes_q | ({{(BUF_W-WORD_W){1'b0}}, push_data} << {cnt_q, 3'b000});
            cnt_q   <= cnt_q + 4'd4;
        end else if (pop) begin
            bytes_q <= bytes_q >> {pop_bytes, 3'b000};
            cnt_q   <= cnt_q - {1'b0, pop_bytes};
        end
    end

    always_comb begin
        case (pop_bytes)
            3'd2:    pixel = {16'b0, bytes_q[15:0]};
            3'd3:    pixel = {8'b0, bytes_q[23:0]};
            default: pixel = bytes_q[WORD_W-1:0];
        endcase
    end

    assign count = cnt_q;
endmodule

// File: rtl/ilo_seq.sv
module ilo_seq
    import ilo_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  cfg_t              cfg,
    input  logic              go,
    input  logic              in_valid,
    input  logic [3:0]        buf_cnt,
    output logic              in_ready,
    output logic              take,
    output logic              emit,
    output logic              line_clr,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [2:0]        wr_bytes,
    output logic              done,
    output logic              running
);
    localparam int NPX_W = FIELD_W + 1;
    localparam int WPL_W = FIELD_W + 2;
    localparam int LB_W  = FIELD_W + 4;

    logic [2:0]         bpb_q;
    logic [FIELD_W-1:0] pitch_q, left_q, x_q, y_q, lines_q;
    logic [NPX_W-1:0]   npx_q, px_left_q;
    logic [WPL_W-1:0]   wpl_q, words_left_q;
    logic               done_q, run_q;

    logic [2:0]       bpb_c;
    logic [NPX_W-1:0] npx_c;
    logic [LB_W-1:0]  lbytes_c;
    logic [WPL_W-1:0] wpl_c;
    logic             start, empty, line_end;

    always_comb begin
        bpb_c    = fmt_bytes(cfg.fmt);
        npx_c    = {1'b0, cfg.xr} - {1'b0, cfg.xl} + NPX_W'(1);
        lbytes_c = LB_W'(npx_c) * LB_W'(bpb_c);
        wpl_c    = WPL_W'((lbytes_c + LB_W'(3)) >> 2);
        start    = go && !run_q;
        empty    = (cfg.len == '0) || (cfg.xr < cfg.xl);
        emit     = run_q && (px_left_q != '0) && (buf_cnt >= {1'b0, bpb_q});
        in_ready = run_q && !emit && (words_left_q != '0);
        take     = in_ready && in_valid;
        line_end = run_q && (px_left_q == '0) && (words_left_q == '0);
        line_clr = start || line_end;
        wr_addr  = (ADDR_W'(y_q) * ADDR_W'(pitch_q) + ADDR_W'(x_q)) * ADDR_W'(bpb_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q        <= 1'b0;
            done_q       <= 1'b0;
            bpb_q        <= 3'd4;
            pitch_q      <= '0;
            left_q       <= '0;
            x_q          <= '0;
            y_q          <= '0;
            lines_q      <= '0;
            npx_q        <= '0;
            px_left_q    <= '0;
            wpl_q        <= '0;
            words_left_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                if (empty) begin
                    done_q <= 1'b1;
                end else begin
                    run_q        <= 1'b1;
                    bpb_q        <= bpb_c;
                    pitch_q      <= cfg.pitch;
                    left_q       <= cfg.xl;
                    x_q          <= cfg.xl;
                    y_q          <= cfg.ydst;
                    lines_q      <= cfg.len;
                    npx_q        <= npx_c;
                    px_left_q    <= npx_c;
                    wpl_q        <= wpl_c;
                    words_left_q <= wpl_c;
                end
            end else if (emit) begin
                x_q       <= x_q + 1'b1;
                px_left_q <= px_left_q - 1'b1;
            end else if (take) begin
                words_left_q <= words_left_q - 1'b1;
            end else if (line_end) begin
                if (lines_q == FIELD_W'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    lines_q      <= lines_q - 1'b1;
                    y_q          <= y_q + 1'b1;
                    x_q          <= left_q;
                    px_left_q    <= npx_q;
                    words_left_q <= wpl_q;
                end
            end
        end
    end

    assign wr_bytes = bpb_q;
    assign done     = done_q;
    assign running  = run_q;
endmodule

// File: rtl/rect_iload.sv
module rect_iload
    import ilo_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              in_valid,
    input  logic [31:0]       in_data,
    output logic              in_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    output logic [2:0]        wr_bytes,
    output logic              done
);
    cfg_t       cfg;
    logic       go, take, emit, line_clr, running;
    logic [3:0] buf_cnt;

    ilo_regs u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cfg(cfg), .go(go)
    );

    ilo_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst(rst), .cfg(cfg), .go(go), .in_valid(in_valid),
        .buf_cnt(buf_cnt), .in_ready(in_ready), .take(take), .emit(emit),
        .line_clr(line_clr), .wr_addr(wr_addr), .wr_bytes(wr_bytes),
        .done(done), .running(running)
    );

    ilo_unpack u_unpack (
        .clk(clk), .rst(rst), .clear(line_clr), .push(take), .push_data(in_data),
        .pop(emit), .pop_bytes(wr_bytes), .count(buf_cnt), .pixel(wr_data)
    );

    assign wr_en = emit;
endmodule

// File: rtl/ilo_checker.sv
module ilo_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_ready,
    input logic       wr_en,
    input logic [2:0] wr_bytes,
    input logic       done,
    input logic       busy
);
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!wr_en && !in_ready));

    a_r6_no_take_while_writing: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && in_ready));

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r1_size_legal: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_bytes == 3'd2 || wr_bytes == 3'd3 || wr_bytes == 3'd4));

    a_r10_size_steady: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !rst && !$past(rst)) |-> $stable(wr_bytes));
endmodule

bind rect_iload ilo_checker u_chk (
    .clk(clk), .rst(rst), .in_ready(in_ready), .wr_en(wr_en),
    .wr_bytes(wr_bytes), .done(done), .busy(running)
);

// File: tb/tb_rect_iload.sv
`timescale 1ns/1ps
module tb_rect_iload;
    localparam int PITCH = 16;
    localparam int MEMSZ = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready, wr_en, done;
    logic [31:0] wr_addr, wr_data;
    logic [2:0]  wr_bytes;

    rect_iload dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_bytes(wr_bytes), .done(done)
    );

    always #2 clk = ~clk;

    int checks = 0, errors = 0;
    int wr_cnt = 0, done_cnt = 0, cyc = 0;
    logic [7:0]  mem_q [MEMSZ];
    logic [7:0]  exp_q [MEMSZ];
    logic [7:0]  sb [4096];
    logic [31:0] words [1024];

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en) begin
                wr_cnt++;
                for (int k = 0; k < int'(wr_bytes); k++)
                    mem_q[(int'(wr_addr) + k) % MEMSZ] = wr_data[8*k +: 8];
            end
            if (done) done_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    function automatic logic [7:0] pb(input int i, input int j, input int k, input int b);
        return 8'((i * 31 + j * 17 + k * 71 + b * 5 + 13) & 255);
    endfunction

    task automatic run_rect(input int fmt, input int xl, input int xr, input int yd,
                            input int nl, input bit poke, input string tag);
        int b, n, tot, nw, w0, d0, idx, mism, t;
        b = (fmt == 0) ? 2 : (fmt == 1) ? 3 : 4;
        n = (xr >= xl) ? xr - xl + 1 : 0;
        for (int a = 0; a < MEMSZ; a++) begin
            mem_q[a] = 8'h5A; exp_q[a] = 8'h5A;
        end
        tot = 0;
        if (n > 0) begin
            for (int i = 0; i < nl; i++) begin
                for (int j = 0; j < n; j++)
                    for (int k = 0; k < b; k++) begin
                        sb[tot] = pb(i, j, k, b); tot++;
                        exp_q[((yd + i) * PITCH + xl + j) * b + k] = pb(i, j, k, b);
                    end
                while (tot % 4 != 0) begin
                    sb[tot] = 8'hA5 ^ 8'(i); tot++;
                end
            end
        end
        nw = tot / 4;
        for (int w = 0; w < nw; w++)
            words[w] = {sb[4*w+3], sb[4*w+2], sb[4*w+1], sb[4*w]};
        w0 = wr_cnt; d0 = done_cnt;
        wr_reg(3'd0, 32'(fmt));
        wr_reg(3'd1, 32'(PITCH));
        wr_reg(3'd2, {16'(xr), 16'(xl)});
        wr_reg(3'd3, 32'(yd));
        wr_reg(3'd5, 32'(nl));
        if (poke) begin
            wr_reg(3'd2, 32'h0007_0001);
            wr_reg(3'd0, 32'd0);
            wr_reg(3'd3, 32'd9);
            wr_reg(3'd5, 32'd4);
        end
        idx = 0;
        while (idx < nw) begin
            @(negedge clk);
            cyc++;
            in_valid = (cyc % 5) != 3;
            in_data  = words[idx];
            if (in_valid && in_ready) idx++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        t = 0;
        while (done_cnt == d0 && t < 3000) begin
            @(negedge clk); t++;
        end
        repeat (4) @(negedge clk);
        check(done_cnt - d0 == 1, {"R8 done count ", tag}, done_cnt - d0, 1);
        check(wr_cnt - w0 == n * nl, {"R3 write count ", tag}, wr_cnt - w0, n * nl);
        mism = 0;
        for (int a = 0; a < MEMSZ; a++) if (mem_q[a] !== exp_q[a]) mism++;
        check(mism == 0, {"R1 R2 R4 R5 frame bytes ", tag}, mism, 0);
        check(in_ready == 1'b0, {"R6 ready low after load ", tag}, int'(in_ready), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int w0, d0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(in_ready == 1'b0, "R11 in_ready after reset", int'(in_ready), 0);
        check(wr_en == 1'b0, "R11 wr_en after reset", int'(wr_en), 0);
        check(done == 1'b0, "R11 done after reset", int'(done), 0);

        // R1 R2 R3 R4 R5: sweep over size, width, offset, lines
        for (int f = 0; f < 4; f++)
            for (int wd = 1; wd <= 6; wd++)
                for (int lo = 0; lo < 2; lo++)
                    for (int nl = 1; nl <= 3; nl += 2)
                        run_rect(f, lo * 5, lo * 5 + wd - 1, 2, nl, 1'b0, "sweep");

        // R9 empty loads
        run_rect(1, 3, 3, 2, 0, 1'b0, "R9 zero lines");
        run_rect(2, 5, 2, 1, 2, 1'b0, "R9 right below left");

        // R10 register writes and restart during a load
        run_rect(1, 2, 6, 3, 3, 1'b1, "R10 busy writes");
        w0 = wr_cnt; d0 = done_cnt;
        repeat (20) @(negedge clk);
        check(done_cnt == d0, "R10 no extra done", done_cnt - d0, 0);

        // R7 plain length register starts nothing
        w0 = wr_cnt; d0 = done_cnt;
        wr_reg(3'd2, 32'h0003_0000);
        wr_reg(3'd4, 32'd2);
        repeat (15) @(negedge clk);
        check(done_cnt == d0, "R7 length without start: done", done_cnt - d0, 0);
        check(wr_cnt == w0, "R7 length without start: writes", wr_cnt - w0, 0);
        check(in_ready == 1'b0, "R7 length without start: ready", int'(in_ready), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule